// File: doc/BRIEF.md
# Three-Region Banked Address Translator

This block widens a 16-bit logical CPU address into a 20-bit physical address, so that an 8-bit processor can reach a 1 MB memory. The logical space is cut on 4 KB page boundaries into three consecutive regions. A low common region starts at address 0. A switchable bank region follows it. A high common region runs up to the top of the logical space.

Two 4-bit boundary fields set where the bank region and the high common region begin. Each of the two upper regions adds its own 8-bit page base to the logical page number. The low common region maps with no offset at all.

Translation is purely combinational. A small write port loads the boundary register and the two bases. The common regions are normally programmed once, while software re-points the bank base whenever it switches banks.

Top module: `banked_xlat`

## Requirements
- R1: After reset the map is the identity onto the first 64 KB. The boundary register resets to 8'hFF and both bases reset to 0, so phys_addr equals {4'h0, log_addr}.
- R2: phys_addr[11:0] always equals log_addr[11:0].
- R3: For a logical page (log_addr[15:12]) below both the bank boundary and the high boundary, phys_addr[19:12] = {4'h0, page}.
- R4: For a page at or above the bank boundary and below the high boundary, phys_addr[19:12] = (bank base + page) mod 256.
- R5: For a page at or above the high boundary, phys_addr[19:12] = (common base + page) mod 256.
- R6: The high region test takes priority over the bank region test. Equal boundaries leave the bank region empty. A boundary of 0 empties every region below it. If the high boundary is set below the bank boundary, pages from the high boundary upward map as high common, and pages below it map as low common.
- R7: A register write takes effect at the clock edge that samples it. During the cycle that presents the write, translation still uses the old value. With wr_en low, the registers hold.
- R8: Register select wr_sel: 0 loads the boundary register, with the high boundary in bits [7:4] and the bank boundary in bits [3:0]. 1 loads the bank base and 2 loads the common base. A write with wr_sel = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| log_addr | input | 16 | Logical CPU address |
| phys_addr | output | 20 | Translated physical address |

## Verification
A register write and a translation through the register being written can fall in the same cycle. The bench provokes this by driving a bank-base write together with an address in the bank region. It then checks that phys_addr still shows the old base before the clock edge and the new base after it. It repeats the same test with the boundary register, so that a page moves from one region to another exactly at the edge.

// File: rtl/banked_xlat.sv
module banked_xlat #(
  parameter int LAW = 16,
  parameter int PAW = 20,
  parameter int OFW = 12,
  parameter logic [7:0] BND_RST = 8'hFF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [7:0]     wr_data,
  input  logic [LAW-1:0] log_addr,
  output logic [PAW-1:0] phys_addr
);
  localparam int LPW = LAW - OFW;
  localparam int PPW = PAW - OFW;

  logic [LPW-1:0] bank_bnd, high_bnd;
  logic [PPW-1:0] bank_base, comm_base;
  logic [LPW-1:0] lpage;
  logic [PPW-1:0] ppage, lpage_x;
  logic in_high, in_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {high_bnd, bank_bnd} <= BND_RST;
      bank_base <= '0;
      comm_base <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: {high_bnd, bank_bnd} <= wr_data;
        2'd1: bank_base <= wr_data;
        2'd2: comm_base <= wr_data;
        default: ;
      endcase
    end
  end

  assign lpage   = log_addr[LAW-1:OFW];
  assign lpage_x = {{(PPW-LPW){1'b0}}, lpage};
  assign in_high = lpage >= high_bnd;
  assign in_bank = !in_high && (lpage >= bank_bnd);

  always_comb begin
    if (in_high)      ppage = comm_base + lpage_x;
    else if (in_bank) ppage = bank_base + lpage_x;
    else              ppage = lpage_x;
  end

  assign phys_addr = {ppage, log_addr[OFW-1:0]};

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFW-1:0] == log_addr[OFW-1:0]);

  assert_low_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lpage < bank_bnd && lpage < high_bnd) |-> phys_addr[PAW-1:OFW] == lpage_x);

  assert_bnd_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> {high_bnd, bank_bnd} == $past(wr_data));

  assert_unused_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> $stable({high_bnd, bank_bnd, bank_base, comm_base}));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({high_bnd, bank_bnd, bank_base, comm_base}));
endmodule

// File: tb/banked_xlat_bench.sv
module banked_xlat_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] log_addr = 0;
  logic [19:0] phys_addr;
  int nvec = 0, nbad = 0;

  always #5 clk = ~clk;

  banked_xlat u_banked_xlat (.clk, .rst_n, .wr_en, .wr_sel, .wr_data, .log_addr, .phys_addr);

  // {boundary, bank base, common base, logical addr, expected physical}
  localparam logic [59:0] VEC [0:13] = '{
    {8'hC4, 8'h10, 8'h80, 16'h1234, 20'h01234},  // R3
    {8'hC4, 8'h10, 8'h80, 16'h4ABC, 20'h14ABC},  // R4
    {8'hC4, 8'h10, 8'h80, 16'hBFFF, 20'h1BFFF},  // R4
    {8'hC4, 8'h10, 8'h80, 16'hC000, 20'h8C000},  // R5
    {8'hC4, 8'h10, 8'h80, 16'hFFFF, 20'h8FFFF},  // R5
    {8'hC4, 8'h10, 8'h80, 16'h3FFF, 20'h03FFF},  // R3
    {8'hF2, 8'hFE, 8'h00, 16'h5001, 20'h03001},  // R4 wrap
    {8'h82, 8'h20, 8'hFA, 16'h9777, 20'h03777},  // R5 wrap
    {8'h66, 8'h40, 8'h30, 16'h5000, 20'h05000},  // R6 empty bank
    {8'h66, 8'h40, 8'h30, 16'h6000, 20'h36000},  // R6 empty bank
    {8'h00, 8'h55, 8'h70, 16'h0123, 20'h70123},  // R6 zero boundaries
    {8'h80, 8'h55, 8'h70, 16'h0FFF, 20'h55FFF},  // R6 bank at page 0
    {8'h39, 8'h11, 8'h22, 16'h5555, 20'h27555},  // R6 inverted
    {8'h39, 8'h11, 8'h22, 16'h2AAA, 20'h02AAA}   // R6 inverted
  };

  task automatic check(input string req, input logic [19:0] exp);
    nvec++;
    if (phys_addr !== exp) begin
      nbad++;
      $display("FAIL %s: la=%h got %h expected %h", req, log_addr, phys_addr, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #100000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    log_addr = 16'hF123; #1 check("R1", 20'h0F123);
    rst_n = 1;
    @(negedge clk);
    log_addr = 16'hF123; #1 check("R1", 20'h0F123);
    log_addr = 16'h0000; #1 check("R1", 20'h00000);
    log_addr = 16'h7ABC; #1 check("R1", 20'h07ABC);

    for (int i = 0; i < 14; i++) begin
      wr(2'd0, VEC[i][59:52]);
      wr(2'd1, VEC[i][51:44]);
      wr(2'd2, VEC[i][43:36]);
      log_addr = VEC[i][35:20];
      #1 check("R2-R6 vector", VEC[i][19:0]);
    end

    // R7: same-cycle write of the bank base and a bank-region access
    wr(2'd0, 8'hC4); wr(2'd1, 8'h10); wr(2'd2, 8'h80);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd1; wr_data = 8'h77; log_addr = 16'h5123;
    #1 check("R7 old bank base", 20'h15123);
    @(posedge clk); #1 check("R7 new bank base", 20'h7C123);
    @(negedge clk); wr_en = 0;
    // R7: same-cycle boundary move, page 5 goes from bank to high
    wr_en = 1; wr_sel = 2'd0; wr_data = 8'h54;
    #1 check("R7 old boundary", 20'h7C123);
    @(posedge clk); #1 check("R7 new boundary", 20'h85123);
    @(negedge clk); wr_en = 0;
    // R7: registers hold with wr_en low although wr_data/wr_sel change
    wr_sel = 2'd1; wr_data = 8'h00;
    repeat (2) @(negedge clk);
    #1 check("R7 hold", 20'h85123);

    // R8: select 3 changes nothing
    log_addr = 16'h4001; #1 check("R8 before", 20'h7B001);
    wr(2'd3, 8'h00);
    #1 check("R8 sel3 bank", 20'h7B001);
    log_addr = 16'h0FFF; #1 check("R8 sel3 low", 20'h00FFF);
    log_addr = 16'hE000; #1 check("R8 sel3 high", 20'h8E000);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule